// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit load/store core that addresses memory in bytes and keeps every instruction on a word boundary. Each clock it chooses the next fetch address from the decoded control-flow kind of the current instruction: the next word, a conditional branch taken relative to the incremented address, a direct jump into the current 256 MB region, a call that also produces a return address, or a jump to an address held in a register.

The decode stage supplies a three-bit kind code, the 16-bit branch displacement counted in words, the 26-bit jump field, a register value and an equality flag from the operand comparator. The unit returns the current address and, for calls, the return address together with a write strobe meant for the return-address register (register 31) of the register file.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter is loaded with the parameter `START_ADDR` (default 0); reset is synchronous.
- R2: Kind code 0 (sequential) advances the program counter by 4; the unused kind codes 6 and 7 behave the same way.
- R3: Kind code 1 (branch on equal) with `operands_equal` high loads (PC+4) + sign-extended displacement × 4; negative displacements move backwards.
- R4: A conditional branch that is not taken (code 1 with `operands_equal` low, or code 2 with `operands_equal` high) advances to PC+4.
- R5: Kind code 2 (branch on not-equal) with `operands_equal` low loads the same target formula as R3.
- R6: Kind code 3 (direct jump) loads {(PC+4)[31:28], jump field, 2'b00}; the top four bits come from the incremented address, so a jump in the last word of a region lands in the next region.
- R7: Kind code 4 (call) loads the same target as R6, and during that cycle `link_addr_o` equals PC+4 and `link_we_o` is high.
- R8: `link_we_o` is low for every kind code other than 4.
- R9: Kind code 5 (register jump) loads `reg_target` unchanged into the program counter.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flow_kind | input | 3 | Control-flow kind of the current instruction (codes in R2 to R9) |
| br_offset | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word index of the direct jump target |
| reg_target | input | 32 | Register value for the register jump |
| operands_equal | input | 1 | High when the two compared register operands match |
| pc_o | output | 32 | Current program counter |
| link_addr_o | output | 32 | Return address (PC+4) |
| link_we_o | output | 1 | Write strobe for the return-address register |

## Verification
The assertions assume that `flow_kind`, the offsets and `operands_equal` are stable and known around every rising edge after reset, and that they describe the instruction at the current program counter. The bench drives every input on the falling edge, leaves them steady through the following rising edge, and samples outputs on the next falling edge. Arbitrary starting addresses, including ones near region ends and near the top of the address space, are reached through the register jump rather than by forcing state.

// File: rtl/pc_seq_pkg.sv
// Package: shared kind encoding for the next program counter unit.
// Assumes the decode stage produces exactly these three-bit codes.
package pc_seq_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_CALL = 3'd4,
        FLOW_JREG = 3'd5
    } flow_kind_e;

endpackage

// File: rtl/pc_incr.sv
// Module: pc_incr
// Produces the address of the following word. Assumes instructions are
// exactly one word (4 bytes) long; the sum wraps at the address width.
module pc_incr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] pc_plus4_o
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    // add one word to the current address
    always_comb begin
        pc_plus4_o = pc_i + WORD_BYTES;
    end

endmodule

// File: rtl/pc_branch_tgt.sv
// Module: pc_branch_tgt
// Computes a relative branch target from the incremented address and a
// signed word displacement. Assumes OFF_W + 2 <= ADDR_W.
module pc_branch_tgt #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] byte_disp;

    generate
        if (EXT_W > 0) begin : g_ext
            // sign-extend and scale the word displacement to bytes
            always_comb begin
                byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
            end
        end else begin : g_noext
            // displacement already fills the address width
            always_comb begin
                byte_disp = {offset_i, 2'b00};
            end
        end
    endgenerate

    // relative target, wrapping at the address width
    always_comb begin
        target_o = base_i + byte_disp;
    end

endmodule

// File: rtl/pc_jump_tgt.sv
// Module: pc_jump_tgt
// Forms a region-local jump target: the upper bits of the incremented
// address followed by the scaled jump field. Assumes JF_W + 2 <= ADDR_W.
module pc_jump_tgt #(
    parameter int ADDR_W = 32,
    parameter int JF_W   = 26
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [JF_W-1:0]   field_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int REGION_W = ADDR_W - JF_W - 2;

    generate
        if (REGION_W > 0) begin : g_region
            // splice the region bits onto the word-scaled field
            always_comb begin
                target_o = {base_i[ADDR_W-1 -: REGION_W], field_i, 2'b00};
            end
        end else begin : g_flat
            // field covers the whole space; base is not needed
            logic unused_base;
            always_comb begin
                unused_base = ^base_i;
                target_o    = {field_i, 2'b00};
            end
        end
    endgenerate

endmodule

// File: rtl/pc_next_sel.sv
// Module: pc_next_sel
// Chooses the next program counter among the candidate addresses from the
// kind code and the equality flag. Unknown codes fall back to sequential.
module pc_next_sel
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        kind_i,
    input  logic              equal_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [ADDR_W-1:0] branch_i,
    input  logic [ADDR_W-1:0] jump_i,
    input  logic [ADDR_W-1:0] reg_i,
    output logic [ADDR_W-1:0] next_o
);

    flow_kind_e kind;

    // decode the raw code and pick the winning candidate
    always_comb begin
        kind = flow_kind_e'(kind_i);
        unique case (kind)
            FLOW_BEQ:           next_o = equal_i ? branch_i : seq_i;
            FLOW_BNE:           next_o = equal_i ? seq_i : branch_i;
            FLOW_JMP,
            FLOW_CALL:          next_o = jump_i;
            FLOW_JREG:          next_o = reg_i;
            default:            next_o = seq_i;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Holds the program counter and advances it once per clock according to
// the current instruction's control-flow kind. Assumes one instruction per
// cycle and that all inputs describe the instruction at pc_o.
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                OFF_W      = 16,
    parameter int                JF_W       = 26,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        flow_kind,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [JF_W-1:0]   jmp_field,
    input  logic [ADDR_W-1:0] reg_target,
    input  logic              operands_equal,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] link_addr_o,
    output logic              link_we_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_plus4;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] jmp_tgt;
    logic [ADDR_W-1:0] pc_next;

    pc_incr #(.ADDR_W(ADDR_W)) u_incr (
        .pc_i       (pc_q),
        .pc_plus4_o (pc_plus4)
    );

    pc_branch_tgt #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_branch (
        .base_i   (pc_plus4),
        .offset_i (br_offset),
        .target_o (br_tgt)
    );

    pc_jump_tgt #(.ADDR_W(ADDR_W), .JF_W(JF_W)) u_jump (
        .base_i   (pc_plus4),
        .field_i  (jmp_field),
        .target_o (jmp_tgt)
    );

    pc_next_sel #(.ADDR_W(ADDR_W)) u_sel (
        .kind_i   (flow_kind),
        .equal_i  (operands_equal),
        .seq_i    (pc_plus4),
        .branch_i (br_tgt),
        .jump_i   (jmp_tgt),
        .reg_i    (reg_target),
        .next_o   (pc_next)
    );

    // program counter register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= START_ADDR;
        else        pc_q <= pc_next;
    end

    // return address and its write strobe for calls
    always_comb begin
        pc_o        = pc_q;
        link_addr_o = pc_plus4;
        link_we_o   = (flow_kind == FLOW_CALL);
    end

    // reset loads the start address
    p_reset_start_r1: assert property (@(posedge clk)
        !rst_n |=> pc_q == START_ADDR);

    // sequential kind steps one word
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_kind == FLOW_SEQ) |=> pc_q == $past(pc_q) + STEP);

    // untaken branch on equal falls through
    p_beq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_kind == FLOW_BEQ && !operands_equal) |=> pc_q == $past(pc_q) + STEP);

    // direct jumps and calls stay word aligned
    p_jump_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_kind == FLOW_JMP || flow_kind == FLOW_CALL) |=> pc_q[1:0] == 2'b00);

    // call return address is the following word of the current pc
    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_addr_o == pc_o + STEP);

    // register jump copies the register value
    p_jreg_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_kind == FLOW_JREG) |=> pc_q == $past(reg_target));

endmodule

// File: tb/pc_sequencer_tb_top.sv
// Bench: directed scenarios for pc_sequencer, one task per scenario.
// Inputs change on the falling edge; outputs are sampled on falling edges.
module pc_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  flow_kind = 3'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] reg_target = '0;
    logic        operands_equal = 1'b0;
    logic [31:0] pc_o;
    logic [31:0] link_addr_o;
    logic        link_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pc_sequencer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .flow_kind      (flow_kind),
        .br_offset      (br_offset),
        .jmp_field      (jmp_field),
        .reg_target     (reg_target),
        .operands_equal (operands_equal),
        .pc_o           (pc_o),
        .link_addr_o    (link_addr_o),
        .link_we_o      (link_we_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one instruction: drive inputs, check strobe, clock, check new pc
    task automatic step(input logic [2:0] k, input logic [15:0] off, input logic [25:0] jf,
                        input logic [31:0] rv, input logic eq, input logic [31:0] exp_pc,
                        input string req);
        flow_kind = k; br_offset = off; jmp_field = jf; reg_target = rv; operands_equal = eq;
        #1;
        check("R8 link strobe", {31'd0, link_we_o}, {31'd0, (k == 3'd4)});
        @(posedge clk);
        @(negedge clk);
        check(req, pc_o, exp_pc);
    endtask

    task automatic load(input logic [31:0] a);
        step(3'd5, 16'd0, 26'd0, a, 1'b0, a, "R9 register jump");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset start", pc_o, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_sequential;
        step(3'd0, 16'h7777, 26'h1, 32'h5, 1'b1, 32'h4, "R2 seq");
        step(3'd0, 16'd0, 26'd0, 32'd0, 1'b0, 32'h8, "R2 seq");
        step(3'd6, 16'd0, 26'd0, 32'd0, 1'b1, 32'hC, "R2 code 6");
        step(3'd7, 16'd0, 26'd0, 32'd0, 1'b0, 32'h10, "R2 code 7");
    endtask

    task automatic t_branches;
        load(32'h0000_0100);
        step(3'd1, 16'd3, 26'd0, 32'd0, 1'b1, 32'h0000_0110, "R3 beq taken forward");
        step(3'd1, 16'hFFFE, 26'd0, 32'd0, 1'b1, 32'h0000_010C, "R3 beq taken backward");
        step(3'd1, 16'd9, 26'd0, 32'd0, 1'b0, 32'h0000_0110, "R4 beq not taken");
        step(3'd2, 16'd1, 26'd0, 32'd0, 1'b0, 32'h0000_0118, "R5 bne taken");
        step(3'd2, 16'd1, 26'd0, 32'd0, 1'b1, 32'h0000_011C, "R4 bne not taken");
        step(3'd2, 16'h8000, 26'd0, 32'd0, 1'b0, 32'hFFFE_0120, "R5 bne most negative");
    endtask

    task automatic t_jumps;
        load(32'h1000_0000);
        step(3'd3, 16'd0, 26'h000_0040, 32'd0, 1'b0, 32'h1000_0100, "R6 jump in region");
        load(32'h2FFF_FFFC);
        step(3'd3, 16'd0, 26'h000_0005, 32'd0, 1'b0, 32'h3000_0014, "R6 jump crosses region");
    endtask

    task automatic t_call;
        load(32'h0000_0200);
        flow_kind = 3'd4; jmp_field = 26'h3FF_FFFF;
        #1;
        check("R7 link address", link_addr_o, 32'h0000_0204);
        check("R7 link strobe", {31'd0, link_we_o}, 32'd1);
        step(3'd4, 16'd0, 26'h3FF_FFFF, 32'd0, 1'b0, 32'h0FFF_FFFC, "R7 call target");
        step(3'd0, 16'd0, 26'd0, 32'd0, 1'b0, 32'h1000_0000, "R8 after call");
    endtask

    task automatic t_register_jump;
        load(32'hDEAD_BEE0);
        load(32'h0000_1233);
    endtask

    task automatic t_wrap;
        load(32'hFFFF_FFFC);
        step(3'd0, 16'd0, 26'd0, 32'd0, 1'b0, 32'h0000_0000, "R10 seq wrap");
        load(32'hFFFF_FFF8);
        step(3'd1, 16'd2, 26'd0, 32'd0, 1'b1, 32'h0000_0004, "R10 branch wrap");
    endtask

    task automatic t_reset_midrun;
        load(32'h4444_4444);
        t_reset;
        step(3'd0, 16'd0, 26'd0, 32'd0, 1'b0, 32'h4, "R1 resume after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_sequential;
        t_branches;
        t_jumps;
        t_call;
        t_register_jump;
        t_wrap;
        t_reset_midrun;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule